// File: doc/BRIEF.md
# Dual-mode watchdog timer

This block is a down counter that serves either as a general-purpose timer or as a watchdog. Software programs it through a simple single-cycle register bus. It sets a reload value, a prescale divider and the operating mode, and then lets the counter run. In timer mode, a count that reaches zero latches an event flag, which can drive a maskable interrupt line. In watchdog mode, the same expiry instead latches a sticky reset flag and issues a one-cycle reset request.

Software services the watchdog by rewriting the load register before the count runs out. Once watchdog mode is entered, an ordinary control write cannot leave it. The only way back to timer mode is a two-word unlock sequence, written in order to a write-only register.

Bus writes take effect at the clock edge at which they are presented. Reads are combinational from the address.

Top module: `dual_wdog`

## Requirements
- R1: After reset, every readable register reads zero, and both `irq_o` and `wdog_rst_o` are low.
- R2: The control register at 0x28 holds the following fields: prescale in bits 15:8, mode in bit 3 (1 = watchdog), interrupt enable in bit 2, auto-reload in bit 1 and run in bit 0. Every other bit reads zero. The disable register at 0x34 always reads zero. The load register at 0x20 reads back the value written to it.
- R3: While the run bit is set, the counter (read at 0x24) decrements once every prescale+1 cycles. While the run bit is clear, the counter holds its value.
- R4: A write to the load register also writes the counter and restarts the prescale phase. The counter can also be written directly at 0x24.
- R5: With auto-reload clear, the counter stops at zero and stays there.
- R6: With auto-reload set, a decrement that would reach zero reloads the counter from the load register instead. The reload period is load×(prescale+1) cycles.
- R7: Bit 0 of 0x2C is an event flag, set by a timer-mode expiry. Writing 1 to that bit clears it. Writing 0 to it has no effect.
- R8: `irq_o` is high exactly when the event flag and interrupt enable are both set and the block is in timer mode.
- R9: A watchdog-mode expiry sets the reset flag in bit 0 of 0x30 and pulses `wdog_rst_o` for one cycle. It does not set the event flag. Writing 1 to bit 0 of 0x30 clears the reset flag.
- R10: While in watchdog mode, a control write with bit 3 = 0 leaves the mode bit set. The other control fields still update.
- R11: Writing 0x12345678 and then 0x87654321 to 0x34 clears the mode bit. Any other word written where the second word is expected restarts the sequence. 0x87654321 written without the first word has no effect.
- R12: In watchdog mode, rewriting the load register restarts the count, so a serviced watchdog does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Timer interrupt (event flag masked by enable) |
| wdog_rst_o | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
A wrong prescale phase or decrement step appears at once in the counter value read at 0x24. It is off by one count within a single prescale period after a load write. A wrong unlock state or mode bit changes the value read back from the control register on the next access. It also turns an expiry into an interrupt instead of a reset pulse, visible in the cycle after the expiring tick. Flag handling faults show up on `irq_o` or in a status read one cycle after the offending write.

// File: rtl/dual_wdog_pkg.sv
package dual_wdog_pkg;

    localparam int DATA_W = 32;
    localparam int PRE_W  = 8;

    // register byte offsets
    localparam int OFS_LOAD  = 'h20;
    localparam int OFS_COUNT = 'h24;
    localparam int OFS_CTRL  = 'h28;
    localparam int OFS_EVT   = 'h2C;
    localparam int OFS_RFLAG = 'h30;
    localparam int OFS_UNLK  = 'h34;

    // control field positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_RELOAD = 1;
    localparam int CTL_IE     = 2;
    localparam int CTL_MODE   = 3;
    localparam int CTL_PRE_LO = 8;

    localparam logic [DATA_W-1:0] UNLOCK_W1 = 32'h1234_5678;
    localparam logic [DATA_W-1:0] UNLOCK_W2 = 32'h8765_4321;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             mode;
        logic             ie;
        logic             reload;
        logic             run;
    } ctrl_t;

    typedef enum logic {
        UL_IDLE,
        UL_ARMED
    } unlock_e;

endpackage

// File: rtl/dual_wdog_presc.sv
module dual_wdog_presc #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);

    logic [W-1:0] phase_d, phase_q;

    always_comb begin
        tick_o  = run_i && !restart_i && (phase_q >= div_i);
        phase_d = phase_q + 1'b1;
        if (!run_i || restart_i || tick_o) begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/dual_wdog_unlock.sv
module dual_wdog_unlock
    import dual_wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              done_o
);

    unlock_e st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (wr_i) begin
            case (st_q)
                UL_IDLE:  st_d = (word_i == UNLOCK_W1) ? UL_ARMED : UL_IDLE;
                UL_ARMED: begin
                    done_o = (word_i == UNLOCK_W2);
                    st_d   = UL_IDLE;
                end
                default:  st_d = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= UL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dual_wdog.sv
module dual_wdog
    import dual_wdog_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctl;
        logic             evt;
        logic             rflag;
        logic             rst;
    } state_t;

    state_t st_d, st_q;

    logic wr_load, wr_cnt, wr_ctl, wr_evt, wr_rflag, wr_unlk;
    logic tick, unlock_done, expire;

    // signals also observed by the bound checker
    logic [CNT_W-1:0] cnt_cur, load_cur;
    logic             mode_cur, ie_cur, evt_cur, rflag_cur;

    always_comb begin
        wr_load  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_LOAD));
        wr_cnt   = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_COUNT));
        wr_ctl   = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_CTRL));
        wr_evt   = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_EVT));
        wr_rflag = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_RFLAG));
        wr_unlk  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_UNLK));
    end

    dual_wdog_presc #(
        .W(PRE_W)
    ) u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (st_q.ctl.run),
        .restart_i(wr_load || wr_cnt),
        .div_i    (st_q.ctl.pre),
        .tick_o   (tick)
    );

    dual_wdog_unlock u_unlock (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wr_i  (wr_unlk),
        .word_i(bus_wdata_i),
        .done_o(unlock_done)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        expire   = 1'b0;

        // write-one-to-clear first, so a same-cycle set wins
        if (wr_evt && bus_wdata_i[0]) begin
            st_d.evt = 1'b0;
        end
        if (wr_rflag && bus_wdata_i[0]) begin
            st_d.rflag = 1'b0;
        end

        // count
        if (tick && (st_q.cnt != '0)) begin
            if (st_q.cnt == CNT_ONE) begin
                expire   = 1'b1;
                st_d.cnt = st_q.ctl.reload ? st_q.load : '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end

        if (expire) begin
            if (st_q.ctl.mode) begin
                st_d.rflag = 1'b1;
                st_d.rst   = 1'b1;
            end else begin
                st_d.evt = 1'b1;
            end
        end

        // bus writes override the count
        if (wr_load) begin
            st_d.load = bus_wdata_i[CNT_W-1:0];
            st_d.cnt  = bus_wdata_i[CNT_W-1:0];
        end
        if (wr_cnt) begin
            st_d.cnt = bus_wdata_i[CNT_W-1:0];
        end
        if (wr_ctl) begin
            st_d.ctl.pre    = bus_wdata_i[CTL_PRE_LO +: PRE_W];
            st_d.ctl.ie     = bus_wdata_i[CTL_IE];
            st_d.ctl.reload = bus_wdata_i[CTL_RELOAD];
            st_d.ctl.run    = bus_wdata_i[CTL_RUN];
            st_d.ctl.mode   = st_q.ctl.mode | bus_wdata_i[CTL_MODE];
        end
        if (unlock_done) begin
            st_d.ctl.mode = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cnt_cur   = st_q.cnt;
        load_cur  = st_q.load;
        mode_cur  = st_q.ctl.mode;
        ie_cur    = st_q.ctl.ie;
        evt_cur   = st_q.evt;
        rflag_cur = st_q.rflag;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFS_LOAD)) begin
            bus_rdata_o = DATA_W'(load_cur);
        end else if (bus_addr_i == ADDR_W'(OFS_COUNT)) begin
            bus_rdata_o = DATA_W'(cnt_cur);
        end else if (bus_addr_i == ADDR_W'(OFS_CTRL)) begin
            bus_rdata_o[CTL_PRE_LO +: PRE_W] = st_q.ctl.pre;
            bus_rdata_o[CTL_MODE]            = mode_cur;
            bus_rdata_o[CTL_IE]              = ie_cur;
            bus_rdata_o[CTL_RELOAD]          = st_q.ctl.reload;
            bus_rdata_o[CTL_RUN]             = st_q.ctl.run;
        end else if (bus_addr_i == ADDR_W'(OFS_EVT)) begin
            bus_rdata_o[0] = evt_cur;
        end else if (bus_addr_i == ADDR_W'(OFS_RFLAG)) begin
            bus_rdata_o[0] = rflag_cur;
        end
    end

    assign irq_o      = evt_cur && ie_cur && !mode_cur;
    assign wdog_rst_o = st_q.rst;

endmodule

// File: rtl/dual_wdog_chk.sv
module dual_wdog_chk
    import dual_wdog_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              irq_o,
    input logic              wdog_rst_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  load_q,
    input logic              mode_q,
    input logic              ie_q,
    input logic              evt_q,
    input logic              rflag_q,
    input logic              unlock_done
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic cnt_written;
    assign cnt_written = bus_sel_i && bus_we_i &&
                         ((bus_addr_i == ADDR_W'(OFS_LOAD)) || (bus_addr_i == ADDR_W'(OFS_COUNT)));

    assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_written |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - ONE) || (cnt_q == $past(load_q)));

    assert_stop_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '0 && !cnt_written) |=> (cnt_q == '0));

    assert_irq_timer_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (evt_q && ie_q && !mode_q));

    assert_rst_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_o |-> rflag_q);

    assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q && !unlock_done) |=> mode_q);

    assert_mode_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unlock_done |=> !mode_q);

endmodule

bind dual_wdog dual_wdog_chk #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o),
    .cnt_q      (cnt_cur),
    .load_q     (load_cur),
    .mode_q     (mode_cur),
    .ie_q       (ie_cur),
    .evt_q      (evt_cur),
    .rflag_q    (rflag_cur),
    .unlock_done(unlock_done)
);

// File: tb/dual_wdog_tb_top.sv
module dual_wdog_tb_top;

    localparam logic [5:0] A_LOAD = 6'h20, A_CNT = 6'h24, A_CTL = 6'h28,
                           A_EVT = 6'h2C, A_RFL = 6'h30, A_UNL = 6'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wrst;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_wdog dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_sel_i  (sel),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq),
        .wdog_rst_o (wrst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected counter k cycles after a load write, no reload
    function automatic logic [31:0] exp_single(input int l, input int p, input int k);
        int n = k / (p + 1);
        return (n >= l) ? 32'd0 : 32'(l - n);
    endfunction

    // expected counter k cycles after a load write, with reload
    function automatic logic [31:0] exp_reload(input int l, input int p, input int k);
        int n = k / (p + 1);
        return 32'(l - (n % l));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog timeout: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240607));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(A_CTL, v);  chk("R1 ctrl", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_LOAD, v); chk("R1 load", v, 0);
        chk("R1 outputs", {30'd0, irq, wrst}, 0);

        // R2 field layout and read-back
        wr(A_CTL, 32'hFFFF_FFF6);
        rd(A_CTL, v);  chk("R2 ctrl mask", v, 32'h0000_FF06);
        wr(A_CTL, 0);
        wr(A_LOAD, 32'hCAFE_0042);
        rd(A_LOAD, v); chk("R2 load readback", v, 32'hCAFE_0042);
        rd(A_UNL, v);  chk("R2 disable reads zero", v, 0);

        // R3/R4 counter write holds while stopped
        wr(A_CNT, 32'h77);
        wait_cyc(5);
        rd(A_CNT, v);  chk("R3 R4 stopped hold", v, 32'h77);

        // R5/R7/R8 single shot with interrupt
        wr(A_CNT, 0);
        wr(A_CTL, 32'h5);
        wr(A_LOAD, 3);
        rd(A_CNT, v);  chk("R4 load loads counter", v, 3);
        wait_cyc(3);
        rd(A_CNT, v);  chk("R5 reaches zero", v, 0);
        chk("R8 irq raised", {31'd0, irq}, 1);
        wr(A_EVT, 0);
        chk("R7 write 0 no clear", {31'd0, irq}, 1);
        wr(A_EVT, 1);
        chk("R7 write 1 clears", {31'd0, irq}, 0);
        wait_cyc(4);
        rd(A_CNT, v);  chk("R5 stays at zero", v, 0);
        rd(A_EVT, v);  chk("R5 no second event", v, 0);

        // R6 auto reload
        wr(A_CTL, 32'h0000_0103);
        wr(A_LOAD, 4);
        wait_cyc(7);
        rd(A_CNT, v);  chk("R6 before reload", v, 1);
        wait_cyc(1);
        rd(A_CNT, v);  chk("R6 reloaded", v, 4);
        rd(A_EVT, v);  chk("R6 event on reload", v, 1);

        // R3 R6 random prescale/load patterns in timer mode
        for (int i = 0; i < 24; i++) begin
            int l = 2 + int'($urandom % 30);
            int p = int'($urandom % 4);
            int ar = int'($urandom % 2);
            int k = int'($urandom % (l * (p + 1) * 2));
            wr(A_CTL, 0);
            wr(A_CNT, 0);
            wr(A_EVT, 1);
            wr(A_CTL, (p << 8) | (ar << 1) | 1);
            wr(A_LOAD, l);
            wait_cyc(k);
            rd(A_CNT, v);
            chk(ar ? "R6 random count" : "R3 random count", v,
                ar ? exp_reload(l, p, k) : exp_single(l, p, k));
            rd(A_EVT, v);
            chk("R7 random event", v, (k >= l * (p + 1)) ? 1 : 0);
        end

        // R9 watchdog expiry
        wr(A_CTL, 0);
        wr(A_CNT, 0);
        wr(A_EVT, 1);
        wr(A_CTL, 32'hD);
        wr(A_LOAD, 5);
        wait_cyc(4);
        chk("R9 no early reset", {31'd0, wrst}, 0);
        wait_cyc(1);
        chk("R9 reset pulse", {31'd0, wrst}, 1);
        chk("R8 irq masked in watchdog", {31'd0, irq}, 0);
        rd(A_RFL, v);  chk("R9 reset flag", v, 1);
        rd(A_EVT, v);  chk("R9 no event flag", v, 0);
        wait_cyc(1);
        chk("R9 pulse one cycle", {31'd0, wrst}, 0);
        wr(A_RFL, 1);
        rd(A_RFL, v);  chk("R9 flag cleared", v, 0);

        // R12 servicing
        wr(A_LOAD, 10);
        wait_cyc(6);
        wr(A_LOAD, 10);
        wait_cyc(6);
        rd(A_CNT, v);  chk("R12 restart count", v, 4);
        rd(A_RFL, v);  chk("R12 no expiry", v, 0);

        // R10 mode cannot be cleared by control write
        wr(A_CTL, 32'h1);
        rd(A_CTL, v);  chk("R10 mode held", v, 32'h9);

        // R11 unlock sequence
        wr(A_UNL, 32'h8765_4321);
        rd(A_CTL, v);  chk("R11 second word alone", v, 32'h9);
        wr(A_UNL, 32'h1234_5678);
        wr(A_UNL, 32'h0000_DEAD);
        wr(A_UNL, 32'h8765_4321);
        rd(A_CTL, v);  chk("R11 broken sequence", v, 32'h9);
        wr(A_UNL, 32'h1234_5678);
        wr(A_UNL, 32'h8765_4321);
        rd(A_CTL, v);  chk("R11 unlocked", v, 32'h1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule